// File: doc/BRIEF.md
# Display Control Register Bank

This block is the register bank that software uses to set up a display scan-out engine. It sits behind a 32-bit write/read port whose address counts in words. Four registers are mapped: a control word, a second control word, the current frame-buffer base and the next frame-buffer base. Each register takes four consecutive word addresses. The first is a plain write. The second ORs the written data into the register. The third clears every bit that is set in the written data. The fourth accepts no write. A read from any of the four returns the register itself.

The control word is decoded into the fields that the pixel formatter and the timing generator use. The next-base register can be written at any time. Its value moves into the current-base register, which the scan-out engine reads, only on a frame-sync pulse, so panning never tears the picture. One bit of the second control word is a write-only strobe that produces a single-cycle FIFO-clear pulse. A soft-reset bit in the control word holds every other register at zero for as long as it stays set.

Top module: `disp_csr_bank`

## Requirements
- R1: While rst_ni is low, every register reads zero, every decoded field is zero, scan_base_o is zero and fifo_clr_o is low.
- R2: Registers sit at word addresses 0 (control), 4 (second control), 8 (current base) and 12 (next base). Address bits [1:0] select the access: 0 is a plain write, and after the clock edge the register holds the written data.
- R3: Access code 1 (word offset +1) ORs the written data into the register.
- R4: Access code 2 (word offset +2) clears in the register every bit that is set in the written data.
- R5: A read at access codes 1, 2 or 3 returns the same value as a read at code 0. A write at code 3 changes nothing. Addresses at word 16 and above read zero and ignore writes.
- R6: Control word fields: bit 0 drives run_o, bit 5 drives bus_master_o, bits [9:8] drive word_len_o, bits [11:10] drive bus_width_o, bit 17 drives dotclk_mode_o, bit 30 drives clk_gate_o and bit 31 drives soft_rst_o.
- R7: A write to the next-base register leaves scan_base_o unchanged. On the first clock edge at which frame_sync_i is high, scan_base_o and the current-base register take the next-base value. A next-base write in that same cycle is held back until the following frame sync.
- R8: Writes to the current-base register, through any access code, have no effect.
- R9: Once control bit 31 is set, every other register bit reads zero from the next edge on. While bit 31 stays set, writes to the other registers and to the other control bits are ignored and frame_sync_i has no effect. Clearing bit 31 restores normal operation.
- R10: A plain or set-alias write to the second control word with data bit 21 high drives fifo_clr_o high for exactly the cycle after the write edge. Bit 21 always reads zero. A clear-alias write produces no pulse. The other bits of the second control word are stored and appear on ctrl2_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 6 | Word address: [5:2] register, [1:0] access code |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| frame_sync_i | input | 1 | Frame boundary pulse |
| run_o | output | 1 | Run enable |
| clk_gate_o | output | 1 | Clock gate request |
| soft_rst_o | output | 1 | Soft reset active |
| dotclk_mode_o | output | 1 | RGB-with-sync-signals mode |
| bus_master_o | output | 1 | Bus-master operation |
| bus_width_o | output | 2 | Panel bus width code |
| word_len_o | output | 2 | Input word-length code |
| ctrl2_o | output | 32 | Second control word (bit 21 always zero) |
| fifo_clr_o | output | 1 | One-cycle FIFO-clear pulse |
| scan_base_o | output | 32 | Current frame-buffer base |

## Verification
Every register is driven through all three access codes, with values chosen so that a set, a clear and a plain write each leave a different result. A read at every alias then shows whether the alias offsets are decoded or ignored. The frame-base pair is tested with a next-base write well before a sync, with a write in the same cycle as a sync, and with writes to the read-only current register. These cases separate a correct double buffer from one that passes writes straight through or swaps a cycle late. Soft reset is raised while other registers hold nonzero values, written against while held, and then released. The FIFO strobe is driven through each alias to confirm the pulse width and that bit 21 never reads back.

// File: rtl/disp_csr_pkg.sv
package disp_csr_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_REGS = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_REGS);

  localparam int unsigned IDX_CTRL  = 0;
  localparam int unsigned IDX_CTRL2 = 1;
  localparam int unsigned IDX_CUR   = 2;
  localparam int unsigned IDX_NEXT  = 3;

  localparam int unsigned B_RUN    = 0;
  localparam int unsigned B_MASTER = 5;
  localparam int unsigned B_WLEN   = 8;
  localparam int unsigned B_BWID   = 10;
  localparam int unsigned B_DOTCLK = 17;
  localparam int unsigned B_CGATE  = 30;
  localparam int unsigned B_SRST   = 31;
  localparam int unsigned B_FCLR   = 21;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_NONE  = 2'd3
  } csr_op_e;

  function automatic logic [WORD_W-1:0] csr_apply(csr_op_e op,
                                                  logic [WORD_W-1:0] q,
                                                  logic [WORD_W-1:0] d);
    case (op)
      OP_WRITE: csr_apply = d;
      OP_SET:   csr_apply = q | d;
      OP_CLR:   csr_apply = q & ~d;
      default:  csr_apply = q;
    endcase
  endfunction
endpackage

// File: rtl/disp_csr_decode.sv
module disp_csr_decode
  import disp_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  output logic [NUM_REGS-1:0] wsel_o,
  output logic [SEL_W-1:0]    ridx_o,
  output logic                hit_o,
  output csr_op_e             op_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;

  assign idx    = addr_i[ADDR_W-1:2];
  assign op_o   = csr_op_e'(addr_i[1:0]);
  assign hit_o  = idx < IDX_W'(NUM_REGS);
  assign ridx_o = idx[SEL_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
    assign wsel_o[i] = we_i && (op_o != OP_NONE) && (idx == IDX_W'(i));
  end
endmodule

// File: rtl/disp_csr_word.sv
module disp_csr_word
  import disp_csr_pkg::*;
#(
  parameter logic [WORD_W-1:0] WMASK     = '1,
  parameter logic [WORD_W-1:0] KEEP_MASK = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  csr_op_e           op_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              clr_i,
  output logic [WORD_W-1:0] q_o
);
  logic [WORD_W-1:0] nxt;

  assign nxt = we_i ? (csr_apply(op_i, q_o, wdata_i) & WMASK) : q_o;

  // clr_i zeroes all but KEEP_MASK bits (soft reset hold)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (clr_i) q_o <= nxt & KEEP_MASK;
    else            q_o <= nxt;
  end
endmodule

// File: rtl/disp_csr_base_pair.sv
module disp_csr_base_pair
  import disp_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  csr_op_e           op_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              clr_i,
  input  logic              swap_i,
  output logic [WORD_W-1:0] cur_o,
  output logic [WORD_W-1:0] next_o
);
  disp_csr_word #(.WMASK('1), .KEEP_MASK('0)) u_next (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .op_i   (op_i),
    .wdata_i(wdata_i),
    .clr_i  (clr_i),
    .q_o    (next_o)
  );

  // swap takes the registered next value, so a same-cycle write waits a frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cur_o <= '0;
    else if (clr_i)  cur_o <= '0;
    else if (swap_i) cur_o <= next_o;
  end
endmodule

// File: rtl/disp_csr_bank.sv
module disp_csr_bank
  import disp_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              frame_sync_i,
  output logic              run_o,
  output logic              clk_gate_o,
  output logic              soft_rst_o,
  output logic              dotclk_mode_o,
  output logic              bus_master_o,
  output logic [1:0]        bus_width_o,
  output logic [1:0]        word_len_o,
  output logic [31:0]       ctrl2_o,
  output logic              fifo_clr_o,
  output logic [31:0]       scan_base_o
);
  localparam logic [WORD_W-1:0] SRST_MASK = WORD_W'(1) << B_SRST;
  localparam logic [WORD_W-1:0] FCLR_MASK = WORD_W'(1) << B_FCLR;

  logic [NUM_REGS-1:0] wsel;
  logic [SEL_W-1:0]    ridx;
  logic                hit;
  csr_op_e             op;

  logic [WORD_W-1:0] ctrl_q, ctrl2_q, cur_q, next_q, ctrl_try;
  logic [WORD_W-1:0] rd_regs [NUM_REGS];
  logic              srst_nxt;
  logic              fclr_q;

  disp_csr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i(bus_addr_i),
    .we_i  (bus_we_i),
    .wsel_o(wsel),
    .ridx_o(ridx),
    .hit_o (hit),
    .op_o  (op)
  );

  // next-state soft reset decides whether the rest of the bank is held at zero
  assign ctrl_try = csr_apply(op, ctrl_q, bus_wdata_i);
  assign srst_nxt = wsel[IDX_CTRL] ? ctrl_try[B_SRST] : ctrl_q[B_SRST];

  disp_csr_word #(.WMASK('1), .KEEP_MASK(SRST_MASK)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wsel[IDX_CTRL]),
    .op_i   (op),
    .wdata_i(bus_wdata_i),
    .clr_i  (srst_nxt),
    .q_o    (ctrl_q)
  );

  disp_csr_word #(.WMASK(~FCLR_MASK), .KEEP_MASK('0)) u_ctrl2 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wsel[IDX_CTRL2]),
    .op_i   (op),
    .wdata_i(bus_wdata_i),
    .clr_i  (srst_nxt),
    .q_o    (ctrl2_q)
  );

  disp_csr_base_pair u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (wsel[IDX_NEXT]),
    .op_i   (op),
    .wdata_i(bus_wdata_i),
    .clr_i  (srst_nxt),
    .swap_i (frame_sync_i),
    .cur_o  (cur_q),
    .next_o (next_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fclr_q <= 1'b0;
    else fclr_q <= wsel[IDX_CTRL2] && (op == OP_WRITE || op == OP_SET) &&
                   bus_wdata_i[B_FCLR] && !srst_nxt;
  end

  assign rd_regs[IDX_CTRL]  = ctrl_q;
  assign rd_regs[IDX_CTRL2] = ctrl2_q;
  assign rd_regs[IDX_CUR]   = cur_q;
  assign rd_regs[IDX_NEXT]  = next_q;

  assign bus_rdata_o   = hit ? rd_regs[ridx] : '0;

  assign run_o         = ctrl_q[B_RUN];
  assign bus_master_o  = ctrl_q[B_MASTER];
  assign word_len_o    = ctrl_q[B_WLEN+:2];
  assign bus_width_o   = ctrl_q[B_BWID+:2];
  assign dotclk_mode_o = ctrl_q[B_DOTCLK];
  assign clk_gate_o    = ctrl_q[B_CGATE];
  assign soft_rst_o    = ctrl_q[B_SRST];
  assign ctrl2_o       = ctrl2_q;
  assign fifo_clr_o    = fclr_q;
  assign scan_base_o   = cur_q;
endmodule

// File: rtl/disp_csr_checker.sv
module disp_csr_checker #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_we_i,
  input logic [31:0]       bus_wdata_i,
  input logic [31:0]       bus_rdata_o,
  input logic              frame_sync_i,
  input logic              run_o,
  input logic              soft_rst_o,
  input logic [31:0]       ctrl2_o,
  input logic              fifo_clr_o,
  input logic [31:0]       scan_base_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  assign idx = bus_addr_i[ADDR_W-1:2];

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_zero: assert (scan_base_o == '0 && ctrl2_o == '0 && !run_o &&
                               !soft_rst_o && !fifo_clr_o);
    end
  end

  a_r6_ctrl_fields_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx == IDX_W'(0)) |-> (bus_rdata_o[0] == run_o && bus_rdata_o[31] == soft_rst_o));

  a_r7_base_waits_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(frame_sync_i) && !soft_rst_o) |-> $stable(scan_base_o));

  a_r9_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (scan_base_o == '0 && ctrl2_o == '0 && !run_o && !fifo_clr_o));

  a_r10_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_o |-> $past(bus_we_i && idx == IDX_W'(1) && !bus_addr_i[1] &&
                         bus_wdata_i[21]));

  a_r10_strobe_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx == IDX_W'(1)) |-> !bus_rdata_o[21]);
endmodule

bind disp_csr_bank disp_csr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_we_i    (bus_we_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_rdata_o (bus_rdata_o),
  .frame_sync_i(frame_sync_i),
  .run_o       (run_o),
  .soft_rst_o  (soft_rst_o),
  .ctrl2_o     (ctrl2_o),
  .fifo_clr_o  (fifo_clr_o),
  .scan_base_o (scan_base_o)
);

// File: tb/tb_disp_csr_bank.sv
module tb_disp_csr_bank;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  bus_addr_i = '0;
  logic        bus_we_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        frame_sync_i = 1'b0;
  logic        run_o, clk_gate_o, soft_rst_o, dotclk_mode_o, bus_master_o;
  logic [1:0]  bus_width_o, word_len_o;
  logic [31:0] ctrl2_o, scan_base_o;
  logic        fifo_clr_o;

  always #5 clk_i = ~clk_i;

  disp_csr_bank dut (.*);

  typedef enum int {K_RD, K_SCAN, K_FIFO, K_FIELDS, K_CTRL2} kind_e;
  typedef struct {
    kind_e       kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done  = 0;

  // requirement model
  logic [31:0] m_ctrl = '0, m_ctrl2 = '0, m_cur = '0, m_nxt = '0;

  function automatic logic [31:0] m_rd(input logic [5:0] a);
    case (a[5:2])
      4'd0: return m_ctrl;
      4'd1: return m_ctrl2;
      4'd2: return m_cur;
      4'd3: return m_nxt;
      default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] m_op(input logic [1:0] op, input logic [31:0] q,
                                       input logic [31:0] d);
    case (op)
      2'd0: return d;
      2'd1: return q | d;
      2'd2: return q & ~d;
      default: return q;
    endcase
  endfunction

  function automatic logic [8:0] m_fields();
    return {m_ctrl[30], m_ctrl[31], m_ctrl[17], m_ctrl[5], m_ctrl[11:10],
            m_ctrl[9:8], m_ctrl[0]};
  endfunction

  task automatic push(input kind_e k, input logic [31:0] e, input string t);
    item_t it;
    it.kind = k; it.exp = e; it.tag = t;
    sb.push_back(it);
  endtask

  // monitor: compare each expected item against the current outputs
  initial begin
    forever begin
      item_t it;
      logic [31:0] got;
      wait (sb.size() > 0);
      it = sb.pop_front();
      case (it.kind)
        K_RD:     got = bus_rdata_o;
        K_SCAN:   got = scan_base_o;
        K_FIFO:   got = {31'd0, fifo_clr_o};
        K_FIELDS: got = {23'd0, clk_gate_o, soft_rst_o, dotclk_mode_o, bus_master_o,
                         bus_width_o, word_len_o, run_o};
        default:  got = ctrl2_o;
      endcase
      n_vec++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, got, it.exp);
      end
    end
  end

  task automatic chk_rd(input logic [5:0] a, input string t);
    @(negedge clk_i);
    bus_addr_i = a;
    #1 push(K_RD, m_rd(a), t);
  endtask

  task automatic chk_outs(input string t);
    #1;
    push(K_SCAN, m_cur, t);
    push(K_FIELDS, {23'd0, m_fields()}, t);
    push(K_CTRL2, m_ctrl2, t);
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d, input bit sync);
    logic [31:0] nv, old_nxt;
    bit srst, fexp, active;
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1; frame_sync_i = sync;
    @(negedge clk_i);
    bus_we_i = 1'b0; frame_sync_i = 1'b0;
    old_nxt = m_nxt;
    active = (a[5:2] < 4) && (a[1:0] != 2'd3);
    nv = m_op(a[1:0], m_rd(a), d);
    srst = (active && a[5:2] == 0) ? nv[31] : m_ctrl[31];
    fexp = 0;
    if (srst) begin
      m_ctrl = (active && a[5:2] == 0) ? (nv & 32'h8000_0000) : 32'h8000_0000;
      m_ctrl2 = '0; m_cur = '0; m_nxt = '0;
    end else begin
      if (active) begin
        case (a[5:2])
          4'd0: m_ctrl = nv;
          4'd1: m_ctrl2 = nv & ~32'h0020_0000;
          4'd3: m_nxt = nv;
          default: ;
        endcase
      end
      fexp = active && a[5:2] == 1 && a[1:0] != 2'd2 && d[21];
      if (sync) m_cur = old_nxt;
    end
    #1 push(K_FIFO, {31'd0, fexp}, "R10");
  endtask

  task automatic frame_pulse();
    @(negedge clk_i);
    frame_sync_i = 1'b1;
    @(negedge clk_i);
    frame_sync_i = 1'b0;
    if (!m_ctrl[31]) m_cur = m_nxt;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    for (int i = 0; i < 16; i += 4) begin
      @(negedge clk_i); bus_addr_i = 6'(i);
      #1 push(K_RD, 32'd0, "R1");
    end
    chk_outs("R1");
    push(K_FIFO, 32'd0, "R1");
    @(negedge clk_i); rst_ni = 1'b1;

    // R2 and R6: plain write and field decode
    bus_wr(6'd0, 32'h0002_0D21, 0);
    chk_rd(6'd0, "R2");
    chk_outs("R6");
    bus_wr(6'd0, 32'h4002_0A20, 0);
    chk_outs("R6");
    // R3: set alias
    bus_wr(6'd1, 32'h0000_0301, 0);
    chk_rd(6'd0, "R3");
    chk_outs("R3");
    // R5: alias reads
    chk_rd(6'd1, "R5");
    chk_rd(6'd2, "R5");
    chk_rd(6'd3, "R5");
    // R4: clear alias
    bus_wr(6'd2, 32'h4000_0201, 0);
    chk_rd(6'd0, "R4");
    chk_outs("R4");
    // R5: code 3 write ignored, unmapped space
    bus_wr(6'd3, 32'hFFFF_FFFF, 0);
    chk_rd(6'd0, "R5");
    bus_wr(6'd16, 32'hFFFF_FFFF, 0);
    chk_rd(6'd16, "R5");
    chk_rd(6'd0, "R5");

    // R10: FIFO strobe
    bus_wr(6'd4, 32'h0020_00F0, 0);
    chk_rd(6'd4, "R10");
    push(K_FIFO, 32'd0, "R10");
    bus_wr(6'd5, 32'h0020_0001, 0);
    chk_rd(6'd5, "R10");
    bus_wr(6'd6, 32'h0020_0010, 0);
    chk_rd(6'd4, "R10");
    chk_outs("R10");

    // R7: double-buffered base
    bus_wr(6'd12, 32'h1000_0000, 0);
    chk_outs("R7");
    chk_rd(6'd12, "R7");
    repeat (3) @(negedge clk_i);
    chk_outs("R7");
    frame_pulse();
    chk_outs("R7");
    chk_rd(6'd8, "R7");
    bus_wr(6'd13, 32'h0000_4000, 0);
    bus_wr(6'd14, 32'h1000_0000, 0);
    chk_rd(6'd12, "R7");
    bus_wr(6'd12, 32'h2222_0000, 1);
    chk_outs("R7");
    chk_rd(6'd12, "R7");
    frame_pulse();
    chk_outs("R7");

    // R8: current base read-only
    bus_wr(6'd8, 32'hDEAD_BEEF, 0);
    bus_wr(6'd9, 32'hFFFF_FFFF, 0);
    bus_wr(6'd10, 32'hFFFF_FFFF, 0);
    chk_rd(6'd8, "R8");
    chk_outs("R8");

    // R9: soft reset
    bus_wr(6'd0, 32'h0002_0021, 0);
    bus_wr(6'd1, 32'h8000_0000, 0);
    chk_outs("R9");
    chk_rd(6'd0, "R9");
    chk_rd(6'd4, "R9");
    chk_rd(6'd12, "R9");
    bus_wr(6'd4, 32'h0020_0FF0, 0);
    bus_wr(6'd1, 32'h0000_0001, 0);
    bus_wr(6'd12, 32'h3333_0000, 1);
    chk_outs("R9");
    chk_rd(6'd12, "R9");
    bus_wr(6'd2, 32'h8000_0000, 0);
    chk_outs("R9");
    bus_wr(6'd12, 32'h4444_0000, 0);
    frame_pulse();
    chk_outs("R9");
    bus_wr(6'd0, 32'h0000_0C01, 0);
    chk_outs("R9");

    @(negedge clk_i);
    wait (sb.size() == 0);
    #1;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule